// File: doc/BRIEF.md
# Register Rename Unit with Free Tag Pool

This block translates architectural register numbers into physical register tags for an out-of-order core, one instruction per cycle. A front-end presents two source registers and one destination register. In the same cycle, the block returns the physical tags that currently hold the sources. It also returns a fresh physical tag taken from a pool of unused tags, and the tag the destination was mapped to until now. The downstream logic keeps that previous tag so that it can be released later.

Two maps are kept. The speculative map is read and written at rename time. The committed map changes only when the retirement logic reports an instruction as retired. Retirement copies no data. It points the committed entry of the destination at the retiring tag and returns the tag that entry previously named to the tail of the pool. On a flush, the speculative map is replaced by the committed map. The pool is then rebuilt to hold every tag that the committed map does not name, in ascending order. When the pool is empty, the block refuses new instructions until a retirement frees a tag.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i in 0..NUM_LOG-1. The pool holds tags NUM_LOG..NUM_PHYS-1 and hands them out in ascending order.
- R2: `ren_psrc1` and `ren_psrc2` always show the speculative mapping of `ren_lsrc1` and `ren_lsrc2`, whether or not `ren_valid` is high.
- R3: An accepted rename (`ren_valid` and `ren_ready` both high) outputs the pool head on `ren_pdst` and the prior speculative mapping of `ren_ldst` on `ren_pold`. From the next cycle on, the destination maps to `ren_pdst`.
- R4: A source equal to the destination of the same instruction returns the mapping that held before that instruction.
- R5: With the pool empty, `ren_ready` is low and a rename request changes neither the map nor the pool.
- R6: A retirement (`cmt_valid`) sets committed entry `cmt_ldst` to `cmt_ptag` and pushes the tag that entry previously held onto the pool tail. Freed tags are handed out again in the order they were freed.
- R7: A rename and a retirement in the same cycle both take effect.
- R8: On `flush`, the speculative map becomes the committed map, including a retirement in the same cycle. `ren_ready` is low during the flush cycle, and a rename in that cycle is ignored.
- R9: After a flush, the pool holds exactly the NUM_PHYS-NUM_LOG tags that the committed map does not name, handed out in ascending order.
- R10: Logical register 0 is renamed like every other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_lsrc1 | input | LW | First source logical register |
| ren_lsrc2 | input | LW | Second source logical register |
| ren_ldst | input | LW | Destination logical register |
| ren_ready | output | 1 | Pool non-empty and no flush; the request is accepted when this and `ren_valid` are high |
| ren_psrc1 | output | PW | Physical tag of first source |
| ren_psrc2 | output | PW | Physical tag of second source |
| ren_pdst | output | PW | Newly allocated destination tag |
| ren_pold | output | PW | Previous speculative tag of destination |
| cmt_valid | input | 1 | Retirement of one instruction |
| cmt_ldst | input | LW | Logical destination of retiring instruction |
| cmt_ptag | input | PW | Physical tag of retiring instruction |
| flush | input | 1 | Discard speculative state |

## Verification
The first pattern renames every logical register in turn. It reads back the same register and the one just renamed, which separates read-before-write from read-after-write and shows that register 0 is not special. A full drain of the pool, followed by retirements, shows whether freed tags return in freeing order and whether a stalled request leaks a tag. A long pseudo-random mix of renames, in-order retirements and flushes, some with a retirement in the same cycle, is compared against a queue model. After each flush, a sweep of every source shows the restored map, and a run of allocations shows the ascending rebuild of the pool.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // next pointer value in a ring of 'depth' slots
  function automatic int wrap_next(input int p, input int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy after one optional push and one optional pop
  function automatic int occ_next(input int c, input bit push, input bit pop);
    return c + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       restore_en,
  input  logic [ENTRIES*TAG_W-1:0]   restore_map,
  output logic [ENTRIES*TAG_W-1:0]   map_q
);
  localparam int IDX_W = $clog2(ENTRIES);

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n)
          map_q[e*TAG_W +: TAG_W] <= TAG_W'(e);
        else if (restore_en)
          map_q[e*TAG_W +: TAG_W] <= restore_map[e*TAG_W +: TAG_W];
        else if (wr_en && wr_idx == IDX_W'(e))
          map_q[e*TAG_W +: TAG_W] <= wr_tag;
      end
    end
  endgenerate
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pop,
  input  logic                                  push,
  input  logic [$clog2(NUM_PHYS)-1:0]           push_tag,
  input  logic                                  rebuild,
  input  logic [NUM_LOG*$clog2(NUM_PHYS)-1:0]   used_map,
  output logic [$clog2(NUM_PHYS)-1:0]           head_tag,
  output logic [$clog2(NUM_PHYS-NUM_LOG+1)-1:0] count,
  output logic                                  empty
);
  import rn_pkg::*;
  localparam int PW   = $clog2(NUM_PHYS);
  localparam int POOL = NUM_PHYS - NUM_LOG;
  localparam int IW   = (POOL > 1) ? $clog2(POOL) : 1;
  localparam int CW   = $clog2(POOL + 1);

  logic [PW-1:0] slot    [POOL];
  logic [PW-1:0] rb_slot [POOL];
  logic [IW-1:0] head, tail;
  logic [NUM_PHYS-1:0] used;
  int            rb_cnt;

  assign head_tag = slot[head];
  assign empty    = (count == '0);

  // compaction of every tag absent from the committed map
  always_comb begin
    used    = '0;
    rb_cnt  = 0;
    rb_slot = '{default: '0};
    for (int i = 0; i < NUM_LOG; i++) used[used_map[i*PW +: PW]] = 1'b1;
    for (int t = 0; t < NUM_PHYS; t++) begin
      if (!used[t] && rb_cnt < POOL) begin
        rb_slot[IW'(rb_cnt)] = PW'(t);
        rb_cnt = rb_cnt + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < POOL; i++) slot[i] <= PW'(NUM_LOG + i);
      head  <= '0;
      tail  <= '0;
      count <= CW'(POOL);
    end else if (rebuild) begin
      slot  <= rb_slot;
      head  <= '0;
      tail  <= IW'(rb_cnt % POOL);
      count <= CW'(rb_cnt);
    end else begin
      if (push) begin
        slot[tail] <= push_tag;
        tail       <= IW'(wrap_next(int'(tail), POOL));
      end
      if (pop) head <= IW'(wrap_next(int'(head), POOL));
      count <= CW'(occ_next(int'(count), push, pop));
    end
  end

  // R5
  pool_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R6
  pool_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !rebuild) |-> (count < CW'(POOL)));
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 64,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [LW-1:0] ren_lsrc1,
  input  logic [LW-1:0] ren_lsrc2,
  input  logic [LW-1:0] ren_ldst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_psrc2,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic [LW-1:0] cmt_ldst,
  input  logic [PW-1:0] cmt_ptag,
  input  logic          flush
);
  localparam int POOL = NUM_PHYS - NUM_LOG;
  localparam int CW   = $clog2(POOL + 1);

  logic [NUM_LOG*PW-1:0] spec_q, cmt_q, cmt_next;
  logic                  ren_fire, pool_empty;
  logic [PW-1:0]         freed_tag, pool_head;
  logic [CW-1:0]         pool_cnt;

  function automatic logic [PW-1:0] tag_of(input logic [NUM_LOG*PW-1:0] m,
                                           input logic [LW-1:0] idx);
    return m[idx*PW +: PW];
  endfunction

  // committed map as it stands after this cycle's retirement
  always_comb begin
    cmt_next = cmt_q;
    if (cmt_valid) cmt_next[cmt_ldst*PW +: PW] = cmt_ptag;
  end

  assign ren_ready = !pool_empty && !flush;
  assign ren_fire  = ren_valid && ren_ready;
  assign freed_tag = tag_of(cmt_q, cmt_ldst);
  assign ren_psrc1 = tag_of(spec_q, ren_lsrc1);
  assign ren_psrc2 = tag_of(spec_q, ren_lsrc2);
  assign ren_pold  = tag_of(spec_q, ren_ldst);
  assign ren_pdst  = pool_head;

  rn_map_table #(.ENTRIES(NUM_LOG), .TAG_W(PW)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ren_fire), .wr_idx(ren_ldst), .wr_tag(pool_head),
    .restore_en(flush), .restore_map(cmt_next),
    .map_q(spec_q)
  );

  rn_map_table #(.ENTRIES(NUM_LOG), .TAG_W(PW)) u_cmt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmt_valid), .wr_idx(cmt_ldst), .wr_tag(cmt_ptag),
    .restore_en(1'b0), .restore_map('0),
    .map_q(cmt_q)
  );

  rn_free_pool #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(ren_fire), .push(cmt_valid), .push_tag(freed_tag),
    .rebuild(flush), .used_map(cmt_next),
    .head_tag(pool_head), .count(pool_cnt), .empty(pool_empty)
  );

  // R3
  spec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |=> tag_of(spec_q, $past(ren_ldst)) == $past(ren_pdst));
  // R6
  cmt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> tag_of(cmt_q, $past(cmt_ldst)) == $past(cmt_ptag));
  // R8
  flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spec_q == cmt_q);
  // R9
  flush_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pool_cnt == CW'(POOL));
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !flush) |=> $stable(spec_q));
endmodule

// File: tb/reg_rename_tb.sv
module reg_rename_tb;
  localparam int NL = 32;
  localparam int NP = 64;

  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, cmt_valid = 0, flush = 0;
  logic [4:0] ren_lsrc1 = 0, ren_lsrc2 = 0, ren_ldst = 0, cmt_ldst = 0;
  logic [5:0] cmt_ptag = 0;
  logic ren_ready;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;

  int checks = 0, errors = 0, cycles = 0;
  int spec [NL];
  int cmap [NL];
  int fq [$];
  int ifl_l [$];
  int ifl_p [$];

  always #5 clk = ~clk;

  reg_rename u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tg, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
    end
  endtask

  task automatic rebuild_pool();
    fq.delete();
    for (int t = 0; t < NP; t++) begin
      bit hit = 0;
      for (int i = 0; i < NL; i++) if (cmap[i] == t) hit = 1;
      if (!hit) fq.push_back(t);
    end
  endtask

  // one cycle: drive, check combinational outputs, advance model
  task automatic cyc(input bit rv, input int s1, input int s2, input int d,
                     input bit cv, input bit fl, input string tsrc, input string tdst);
    bit rdy;
    int cl = 0, ct = 0;
    @(negedge clk);
    if (cv) begin cl = ifl_l[0]; ct = ifl_p[0]; end
    ren_valid = rv; ren_lsrc1 = 5'(s1); ren_lsrc2 = 5'(s2); ren_ldst = 5'(d);
    cmt_valid = cv; cmt_ldst = 5'(cl); cmt_ptag = 6'(ct); flush = fl;
    #1;
    rdy = (fq.size() > 0) && !fl;
    chk((fl ? "R8" : "R5"), int'(ren_ready), int'(rdy));
    chk((s1 == d) ? "R4" : tsrc, int'(ren_psrc1), spec[s1]);
    chk(tsrc, int'(ren_psrc2), spec[s2]);
    if (rv && rdy) begin
      chk(tdst, int'(ren_pdst), fq[0]);
      chk("R3", int'(ren_pold), spec[d]);
    end
    @(posedge clk);
    if (rv && rdy) begin
      int tg = fq.pop_front();
      spec[d] = tg;
      ifl_l.push_back(d); ifl_p.push_back(tg);
    end
    if (cv) begin
      void'(ifl_l.pop_front()); void'(ifl_p.pop_front());
      fq.push_back(cmap[cl]);
      cmap[cl] = ct;
    end
    if (fl) begin
      for (int i = 0; i < NL; i++) spec[i] = cmap[i];
      rebuild_pool();
      ifl_l.delete(); ifl_p.delete();
    end
  endtask

  task automatic sweep_map(input string tg);
    for (int i = 0; i < NL; i++) cyc(0, i, NL - 1 - i, 0, 0, 0, tg, tg);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin spec[i] = i; cmap[i] = i; end
    for (int t = NL; t < NP; t++) fq.push_back(t);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset mapping is identity
    sweep_map("R1");
    // R1 R10: drain pool, register 0 first; source 2 reads previous rename (R3)
    for (int i = 0; i < NL; i++) cyc(1, i, (i + NL - 1) % NL, i, 0, 0, "R3", (i == 0) ? "R10" : "R1");
    // R5: stalled requests change nothing
    repeat (3) cyc(1, 1, 2, 7, 0, 0, "R5", "R5");
    sweep_map("R5");
    // R6 R7: retire while renaming; freed tags come back in freeing order
    cyc(0, 0, 0, 0, 1, 0, "R2", "R6");
    for (int k = 0; k < 8; k++) cyc(1, k, k + 3, 31 - k, 1, 0, "R7", "R6");
    // mixed traffic with flushes
    for (int n = 0; n < 1500; n++) begin
      bit fl = ($urandom_range(0, 59) == 0);
      bit cv = (ifl_l.size() > 0) && ($urandom_range(0, 2) != 0);
      bit rv = ($urandom_range(0, 3) != 0);
      cyc(rv, $urandom_range(0, NL - 1), $urandom_range(0, NL - 1),
          $urandom_range(0, NL - 1), cv, fl, "R2", fl ? "R8" : "R3");
      if (fl) begin
        // R8: restored map; R9: ascending rebuilt pool
        sweep_map("R8");
        for (int i = 0; i < 6; i++) cyc(1, i, i + 1, (i * 5) % NL, 0, 0, "R2", "R9");
      end
    end
    // final flush with retirement in the same cycle
    cyc(0, 0, 0, 0, (ifl_l.size() > 0), 1, "R8", "R8");
    sweep_map("R8");
    for (int i = 0; i < NP - NL; i++) cyc(1, 0, 1, i % NL, 0, 0, "R2", "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule